// File: doc/BRIEF.md
# Aligned Page-Range Bitmap Allocator

This block hands out contiguous runs of I/O page slots and takes them back. Slot occupancy lives in a bitmap built from fixed-width words. A set bit marks a slot as taken. Inside each word the most significant bit stands for the lowest slot address. An allocate request names a page count. The block answers with the index of the first slot of a free run that is aligned to the run size, or with a failure flag. A free request names a starting index and a count, and it clears those slots once it has confirmed that all of them were taken.

To spread allocations over the bitmap, the block keeps a resume hint made of a word pointer and a bit offset. Each search starts from the hint and examines one bitmap word per clock cycle. When the scan runs off the end of the bitmap, the hint returns to the first word and the search is tried one more time. The request fails only if that second pass also finds nothing. A running count of the slots in use is always visible on a port.

Requests arrive through a valid/ready handshake, and only one request is in flight at a time. Every request, whether it succeeds or not, ends with a single-cycle done pulse.

Top module: `pra_alloc_top`

## Requirements
- R1: A bitmap bit set to 1 means the slot is in use. Bit W-1 of word k is slot k*W and bit 0 is slot k*W+W-1. The returned index equals word*W + offset, where offset counts down from the MSB. No allocation ever sets a bit that is already set.
- R2: A count greater than W/2 considers only words that are entirely zero. It returns offset 0 of the first empty word reached, and it sets the top n bits of that word.
- R3: A count of W/2 or less uses an alignment step a, the smallest power of two that is at least n. The result is the lowest offset at or after the start position that is a multiple of a and whose n slots are all free.
- R4: A search starts at the hint word. For the R3 case it starts at the hint offset rounded up to a multiple of a. If the rounded offset reaches W, the search starts at offset 0 of the next word. The R2 case always starts at offset 0 of the hint word.
- R5: After an R3 allocation, the hint becomes (same word, offset + n). After an R2 allocation, the hint becomes (next word, 0).
- R6: When a scan passes the last word, the hint is set to (0, 0) and the search runs once more from there. The request fails (rsp_fail_o=1) only if the second pass also fails. A failure changes neither the bitmap nor the used count.
- R7: A free request whose n slots are all set clears exactly those slots and reports rsp_err_o=0.
- R8: A free request with any of its slots already clear, or with a run that crosses a word boundary (offset + n > W), raises rsp_err_o and changes nothing.
- R9: A count of 0 or of W or more is rejected. An allocate reports rsp_fail_o, a free reports rsp_err_o, and neither changes any state.
- R10: req_ready_o is high only when the block is idle and no done pulse is showing. rsp_done_o lasts exactly one cycle, and two done pulses are never back to back.
- R11: used_o rises by n on each successful allocation and falls by n on each successful free. It never exceeds W*NW.
- R12: After reset the bitmap is empty, the hint is (0, 0), used_o is 0, rsp_done_o is 0 and req_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_free_i | input | 1 | 1 = free request, 0 = allocate request |
| req_count_i | input | $clog2(W)+1 | Number of slots in the run |
| req_index_i | input | $clog2(W*NW) | Starting slot index (free requests only) |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_fail_o | output | 1 | Allocation failed (valid while rsp_done_o is high) |
| rsp_err_o | output | 1 | Free request rejected (valid while rsp_done_o is high) |
| rsp_index_o | output | $clog2(W*NW) | Allocated starting index (valid on success) |
| used_o | output | $clog2(W*NW+1) | Number of slots in use |

## Verification
The bench builds the block with W=8 and NW=4, which gives 32 slots. With so few slots, a short request sequence can fill words, push the rounded hint past a word's end, and push it past the last word. That exercises the wrap and retry path and a full failure after both passes. The narrow word also makes it easy to reach the border between an aligned small run and a whole-word run (count 4 against count 5), a free run that crosses a word, and out-of-range counts, all while tracking the used count by hand.

// File: rtl/pra_pkg.sv
package pra_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FREE = 2'd2
  } pra_state_e;
endpackage

// File: rtl/pra_run_mask.sv
module pra_run_mask #(
  parameter int unsigned W  = 32,
  localparam int unsigned OW = $clog2(W) + 1,
  localparam int unsigned BW = $clog2(W)
) (
  input  logic [OW-1:0] count_i,
  input  logic [BW-1:0] off_i,
  output logic [W-1:0]  mask_o
);
  // top count bits, moved down by the offset (MSB = lowest slot)
  logic [W-1:0] top_run;
  assign top_run = ~({W{1'b1}} >> count_i);
  assign mask_o  = top_run >> off_i;
endmodule

// File: rtl/pra_word_scan.sv
module pra_word_scan #(
  parameter int unsigned W  = 32,
  localparam int unsigned OW = $clog2(W) + 1
) (
  input  logic [W-1:0]  word_i,
  input  logic [OW-1:0] count_i,
  input  logic [OW-1:0] align_i,
  input  logic [OW-1:0] start_i,
  input  logic          wide_i,
  output logic          hit_o,
  output logic [OW-1:0] off_o
);
  logic [W-1:0]  top_run;
  logic [OW-1:0] align_m1;

  assign top_run  = ~({W{1'b1}} >> count_i);
  assign align_m1 = align_i - OW'(1);

  // lowest aligned free candidate at or after start
  always_comb begin
    hit_o = 1'b0;
    off_o = '0;
    for (int k = 0; k < W; k++) begin
      if (!hit_o && (OW'(k) >= start_i) && ((OW'(k) & align_m1) == '0) &&
          ((word_i & (top_run >> k)) == '0) &&
          (!wide_i || ((k == 0) && (word_i == '0)))) begin
        hit_o = 1'b1;
        off_o = OW'(k);
      end
    end
  end
endmodule

// File: rtl/pra_bitmap.sv
module pra_bitmap #(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 16,
  localparam int unsigned AW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic [W-1:0]  rdata_o,
  input  logic          wr_en_i,
  input  logic          wr_set_i,
  input  logic [W-1:0]  wr_mask_i
);
  logic [W-1:0] word_q [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '0;
      end else if (wr_en_i && (addr_i == AW'(g))) begin
        if (wr_set_i) word_q[g] <= word_q[g] | wr_mask_i;
        else          word_q[g] <= word_q[g] & ~wr_mask_i;
      end
    end
  end

  assign rdata_o = word_q[addr_i];

  AST_SET_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_set_i) |-> ((word_q[addr_i] & wr_mask_i) == '0)); // R1

  AST_CLEAR_ONLY_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_set_i) |-> ((word_q[addr_i] & wr_mask_i) == wr_mask_i)); // R7
endmodule

// File: rtl/pra_alloc_top.sv
module pra_alloc_top
  import pra_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 16,
  localparam int unsigned OW = $clog2(W) + 1,
  localparam int unsigned BW = $clog2(W),
  localparam int unsigned AW = $clog2(NW),
  localparam int unsigned WW = AW + 1,
  localparam int unsigned IW = $clog2(W * NW),
  localparam int unsigned UW = $clog2(W * NW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_free_i,
  input  logic [OW-1:0] req_count_i,
  input  logic [IW-1:0] req_index_i,
  output logic          rsp_done_o,
  output logic          rsp_fail_o,
  output logic          rsp_err_o,
  output logic [IW-1:0] rsp_index_o,
  output logic [UW-1:0] used_o
);
  pra_state_e    state_q;
  logic          op_free_q, wide_q, retry_q;
  logic [OW-1:0] cnt_q, align_q, start_q;
  logic [WW-1:0] cur_q;
  logic [AW-1:0] hint_w_q;
  logic [OW-1:0] hint_o_q;
  logic [IW-1:0] fidx_q;
  logic          done_q, fail_q, err_q;
  logic [IW-1:0] ridx_q;
  logic [UW-1:0] used_q;

  // request decode
  logic          accept, cnt_ok, wide_d;
  logic [OW-1:0] align_d;
  logic [OW:0]   round_sum, round_off;
  logic [WW-1:0] start_w_d;
  logic [OW-1:0] start_o_d;

  assign req_ready_o = (state_q == ST_IDLE) && !done_q;
  assign accept      = req_valid_i && req_ready_o;
  assign cnt_ok      = (req_count_i != '0) && (req_count_i < OW'(W));
  assign wide_d      = req_count_i > OW'(W / 2);

  always_comb begin
    align_d = OW'(1);
    for (int i = 0; i < BW; i++) begin
      if (align_d < req_count_i) align_d = align_d << 1;
    end
    if (wide_d) align_d = OW'(W);
  end

  assign round_sum = {1'b0, hint_o_q} + {1'b0, align_d} - (OW+1)'(1);
  assign round_off = round_sum & ~({1'b0, align_d} - (OW+1)'(1));

  always_comb begin
    if (wide_d) begin
      start_w_d = {1'b0, hint_w_q};
      start_o_d = '0;
    end else if (round_off >= (OW+1)'(W)) begin
      start_w_d = {1'b0, hint_w_q} + WW'(1);
      start_o_d = '0;
    end else begin
      start_w_d = {1'b0, hint_w_q};
      start_o_d = round_off[OW-1:0];
    end
  end

  // bitmap and datapath
  logic          past_end;
  logic [AW-1:0] bm_addr;
  logic [W-1:0]  bm_rdata, run_mask;
  logic [BW-1:0] mask_off;
  logic          scan_hit;
  logic [OW-1:0] scan_off;
  logic [BW-1:0] free_off;
  logic          free_fit, free_ok;
  logic          bm_wr, bm_set;

  assign past_end = cur_q >= WW'(NW);
  assign free_off = fidx_q[BW-1:0];
  assign bm_addr  = (state_q == ST_FREE) ? fidx_q[IW-1:BW] : cur_q[AW-1:0];
  assign mask_off = (state_q == ST_FREE) ? free_off : scan_off[BW-1:0];

  pra_bitmap #(.W(W), .NW(NW)) u_bitmap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (bm_addr),
    .rdata_o  (bm_rdata),
    .wr_en_i  (bm_wr),
    .wr_set_i (bm_set),
    .wr_mask_i(run_mask)
  );

  pra_word_scan #(.W(W)) u_scan (
    .word_i (bm_rdata),
    .count_i(cnt_q),
    .align_i(align_q),
    .start_i(start_q),
    .wide_i (wide_q),
    .hit_o  (scan_hit),
    .off_o  (scan_off)
  );

  pra_run_mask #(.W(W)) u_mask (
    .count_i(cnt_q),
    .off_i  (mask_off),
    .mask_o (run_mask)
  );

  assign free_fit = ({1'b0, free_off} + cnt_q) <= OW'(W);
  assign free_ok  = free_fit && ((bm_rdata & run_mask) == run_mask);
  assign bm_set   = (state_q == ST_SCAN);
  assign bm_wr    = ((state_q == ST_SCAN) && !past_end && scan_hit) ||
                    ((state_q == ST_FREE) && free_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_free_q <= 1'b0;
      wide_q    <= 1'b0;
      retry_q   <= 1'b0;
      cnt_q     <= '0;
      align_q   <= OW'(1);
      start_q   <= '0;
      cur_q     <= '0;
      hint_w_q  <= '0;
      hint_o_q  <= '0;
      fidx_q    <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      err_q     <= 1'b0;
      ridx_q    <= '0;
      used_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_free_q <= req_free_i;
            cnt_q     <= req_count_i;
            if (!cnt_ok) begin
              done_q <= 1'b1;
              fail_q <= !req_free_i;
              err_q  <= req_free_i;
            end else if (req_free_i) begin
              fidx_q  <= req_index_i;
              state_q <= ST_FREE;
            end else begin
              wide_q  <= wide_d;
              align_q <= align_d;
              cur_q   <= start_w_d;
              start_q <= start_o_d;
              retry_q <= 1'b0;
              state_q <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (past_end) begin
            hint_w_q <= '0;
            hint_o_q <= '0;
            if (!retry_q) begin
              retry_q <= 1'b1;
              cur_q   <= '0;
              start_q <= '0;
            end else begin
              done_q  <= 1'b1;
              fail_q  <= 1'b1;
              err_q   <= 1'b0;
              state_q <= ST_IDLE;
            end
          end else if (scan_hit) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b0;
            err_q   <= 1'b0;
            ridx_q  <= {cur_q[AW-1:0], scan_off[BW-1:0]};
            used_q  <= used_q + UW'(cnt_q);
            state_q <= ST_IDLE;
            if (wide_q) begin
              hint_w_q <= cur_q[AW-1:0] + AW'(1); // wraps to 0 after last word
              hint_o_q <= '0;
            end else begin
              hint_w_q <= cur_q[AW-1:0];
              hint_o_q <= scan_off + cnt_q;
            end
          end else begin
            cur_q   <= cur_q + WW'(1);
            start_q <= '0;
          end
        end
        ST_FREE: begin
          done_q  <= 1'b1;
          fail_q  <= 1'b0;
          err_q   <= !free_ok;
          state_q <= ST_IDLE;
          if (free_ok) used_q <= used_q - UW'(cnt_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_done_o  = done_q;
  assign rsp_fail_o  = fail_q;
  assign rsp_err_o   = err_q;
  assign rsp_index_o = ridx_q;
  assign used_o      = used_q;

  AST_ALIGNED_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !rsp_fail_o && !rsp_err_o && !op_free_q) |->
      ((rsp_index_o & IW'(align_q - OW'(1))) == '0)); // R3

  AST_WIDE_EMPTY_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SCAN) && !past_end && scan_hit && wide_q) |-> (bm_rdata == '0)); // R2

  AST_REJECT_KEEPS_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && (rsp_fail_o || rsp_err_o)) |-> (used_o == $past(used_o))); // R6

  AST_USED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= UW'(W * NW)); // R11

  AST_NO_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R10
endmodule

// File: tb/tb_pra_alloc_top.sv
module tb_pra_alloc_top;
  localparam int unsigned W  = 8;
  localparam int unsigned NW = 4;
  localparam int unsigned OW = $clog2(W) + 1;
  localparam int unsigned IW = $clog2(W * NW);
  localparam int unsigned UW = $clog2(W * NW + 1);
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic          req_free_i = 1'b0;
  logic [OW-1:0] req_count_i = '0;
  logic [IW-1:0] req_index_i = '0;
  logic          rsp_done_o, rsp_fail_o, rsp_err_o;
  logic [IW-1:0] rsp_index_o;
  logic [UW-1:0] used_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pra_alloc_top #(.W(W), .NW(NW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_free_i(req_free_i), .req_count_i(req_count_i), .req_index_i(req_index_i),
    .rsp_done_o(rsp_done_o), .rsp_fail_o(rsp_fail_o), .rsp_err_o(rsp_err_o),
    .rsp_index_o(rsp_index_o), .used_o(used_o)
  );

  typedef struct packed {
    logic       op;    // 1 = free
    logic [3:0] cnt;
    logic [4:0] idx;
    logic [4:0] e_idx;
    logic       e_flag; // fail for allocate, err for free
    logic [5:0] e_used;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd3, 5'd0,  5'd0,  1'b0, 6'd3,  4'd3},  // R3 first run at 0
    '{1'b0, 4'd1, 5'd0,  5'd3,  1'b0, 6'd4,  4'd5},  // R5 hint offset 3
    '{1'b0, 4'd2, 5'd0,  5'd4,  1'b0, 6'd6,  4'd4},  // R4 rounded start
    '{1'b0, 4'd5, 5'd0,  5'd8,  1'b0, 6'd11, 4'd2},  // R2 whole word
    '{1'b0, 4'd4, 5'd0,  5'd16, 1'b0, 6'd15, 4'd5},  // R5 hint next word
    '{1'b0, 4'd4, 5'd0,  5'd20, 1'b0, 6'd19, 4'd3},
    '{1'b0, 4'd3, 5'd0,  5'd24, 1'b0, 6'd22, 4'd4},  // R4 rounded to W
    '{1'b0, 4'd6, 5'd0,  5'd0,  1'b1, 6'd22, 4'd6},  // R6 both passes fail
    '{1'b1, 4'd5, 5'd8,  5'd0,  1'b0, 6'd17, 4'd7},  // R7
    '{1'b1, 4'd1, 5'd8,  5'd0,  1'b1, 6'd17, 4'd8},  // R8 already clear
    '{1'b0, 4'd6, 5'd0,  5'd8,  1'b0, 6'd23, 4'd2},
    '{1'b0, 4'd2, 5'd0,  5'd28, 1'b0, 6'd25, 4'd3},  // R3 skip busy candidates
    '{1'b0, 4'd2, 5'd0,  5'd30, 1'b0, 6'd27, 4'd1},  // R1 last slot
    '{1'b0, 4'd2, 5'd0,  5'd6,  1'b0, 6'd29, 4'd6},  // R6 wrap then hit
    '{1'b0, 4'd1, 5'd0,  5'd14, 1'b0, 6'd30, 4'd4},
    '{1'b1, 4'd2, 5'd28, 5'd0,  1'b0, 6'd28, 4'd11}, // R11 decrement
    '{1'b0, 4'd0, 5'd0,  5'd0,  1'b1, 6'd28, 4'd9},  // R9 zero count
    '{1'b0, 4'd8, 5'd0,  5'd0,  1'b1, 6'd28, 4'd9},  // R9 count W
    '{1'b1, 4'd3, 5'd6,  5'd0,  1'b1, 6'd28, 4'd8},  // R8 crosses word
    '{1'b1, 4'd0, 5'd0,  5'd0,  1'b1, 6'd28, 4'd9}   // R9 free zero
  };

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic op, input int cnt, input int idx,
                         output int g_idx, output int g_flag, output int g_used);
    int guard;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1;
    req_free_i  = op;
    req_count_i = OW'(cnt);
    req_index_i = IW'(idx);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(int'(req_ready_o), 0, "R10 ready low after accept");
    guard = 0;
    while (!rsp_done_o && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    g_idx  = int'(rsp_index_o);
    g_flag = op ? int'(rsp_err_o) : int'(rsp_fail_o);
    g_used = int'(used_o);
    chk(int'(rsp_done_o), 1, "R10 done seen");
    @(negedge clk);
    chk(int'(rsp_done_o), 0, "R10 done single cycle");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int gi, gf, gu;
    do_reset();
    // R12 reset state
    chk(int'(req_ready_o), 1, "R12 ready");
    chk(int'(rsp_done_o), 0, "R12 done");
    chk(int'(used_o), 0, "R12 used");

    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v].op, int'(VEC[v].cnt), int'(VEC[v].idx), gi, gf, gu);
      chk(gf, int'(VEC[v].e_flag), $sformatf("R%0d vec%0d flag", VEC[v].rq, v));
      if (!VEC[v].e_flag && !VEC[v].op)
        chk(gi, int'(VEC[v].e_idx), $sformatf("R%0d vec%0d index", VEC[v].rq, v));
      chk(gu, int'(VEC[v].e_used), $sformatf("R11 vec%0d used", v));
    end

    // R12 reset mid-run clears bitmap, hint and count
    do_reset();
    chk(int'(used_o), 0, "R12 used after reset");
    run_req(1'b0, 7, 0, gi, gf, gu);
    chk(gi, 0, "R12 empty map wide at 0");
    run_req(1'b0, 4, 0, gi, gf, gu);
    chk(gi, 8, "R5 hint after wide");
    run_req(1'b1, 7, 0, gi, gf, gu);
    chk(gf, 0, "R7 free wide run");
    run_req(1'b0, 2, 0, gi, gf, gu);
    chk(gi, 12, "R5 small hint offset kept");
    run_req(1'b0, 7, 0, gi, gf, gu);
    chk(gi, 16, "R2 wide skips partly used word");
    chk(gu, 13, "R11 used after mix");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule